// File: doc/BRIEF.md
# Register-File Byte Burst Mover

This block copies a run of bytes between a small general-purpose register file and a byte-wide data memory port. A load pulls bytes from memory into registers; a store pushes register bytes out to memory. The command names a direction, a memory byte address, a byte count, and a starting position given as a register index plus a byte lane. The position walks one byte per cycle, lane by lane, and rolls into lane 0 of the next register after lane 3.

Before any byte moves, the block screens the whole command. A span that would run past the end of the register file, an address inside the instruction region (or a span that reaches into it), and, when the null-trap option is on, an address below 4, are all refused. A refused command gives an error pulse with a cause code and touches neither memory nor registers. Accepted commands cost a check cycle, two memory-latency cycles, one cycle per byte, and two pipeline-drain cycles, then give a done pulse. The register file sits inside the block and keeps a host word-write port and a host read port, which are the core's normal way to reach its registers.

Top module: `byte_burst_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `mem_en_o` are 0, `err_code_o` is 0, and every register reads 0.
- R2: A command is taken only when `cmd_valid` is high while `busy_o` is low; a command presented while busy is dropped and has no effect on memory, registers or the result pulses.
- R3: The byte position starts at register `cmd_reg`, lane `cmd_lane` (lane 0 = bits 7:0, lane 3 = bits 31:24) and steps up by one lane per byte; after lane 3 it moves to lane 0 of the next register.
- R4: A load writes memory byte k into the lane of position k and leaves every other lane of that register unchanged.
- R5: Memory accesses are one per cycle, exactly `cmd_len` of them, at `cmd_addr`, `cmd_addr`+1, and so on; a store writes the register byte at position k to address `cmd_addr`+k.
- R6: When cmd_reg*4 + cmd_lane + cmd_len is greater than 128 the command is refused with `err_code_o` = 1 and nothing is transferred; a sum of exactly 128 is legal.
- R7: With `trap_null_en` high, a command whose address is below 4 is refused with `err_code_o` = 2; with it low the same command runs normally.
- R8: A command with `cmd_addr` at or above `CODE_BASE`, or with `cmd_addr` + `cmd_len` above `CODE_BASE`, is refused with `err_code_o` = 2; ending exactly at `CODE_BASE` is legal.
- R9: When a command breaks both an address rule and the length rule, the address cause (code 2) is reported.
- R10: A refused command raises `err_o` one cycle after the accepting edge; a legal command with length n > 0 raises `done_o` n+5 cycles after the accepting edge.
- R11: A legal command with length 0 raises `done_o` one cycle after acceptance and makes no memory access and no register change.
- R12: `done_o` and `err_o` are single-cycle pulses, never high together, exactly one per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_null_en | input | 1 | Refuse accesses below address 4 |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| cmd_addr | input | ADDR_W | First memory byte address |
| cmd_len | input | LEN_W | Number of bytes |
| cmd_reg | input | IDX_W | First register index |
| cmd_lane | input | LANE_W | First byte lane |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Command refused pulse |
| err_code_o | output | 2 | Cause: 1 length, 2 unmapped address |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, one cycle after the strobe |
| rf_wr_en | input | 1 | Host register word write |
| rf_wr_idx | input | IDX_W | Host write register index |
| rf_wr_data | input | DATA_W | Host write word |
| rf_rd_idx | input | IDX_W | Host read register index |
| rf_rd_data | output | DATA_W | Host read word |

## Verification
A wrong byte position shows up as a register or memory byte landing one lane or one register away from its expected place, visible at the host read port or the memory model immediately after the done pulse. A faulty range screen shows within one cycle of acceptance as a done pulse where an error was expected (or the reverse), and as memory strobes for a command that should have been silent. Errors in the wait or drain counts shift the done pulse off its n+5 cycle slot, which the scoreboard catches against the cycle it recorded at acceptance; a load lane mask that is too wide corrupts the neighbouring lanes that the bench preloads with known values.

// File: rtl/bbe_pkg.sv
package bbe_pkg;

  typedef enum logic [1:0] {
    BBE_ERR_NONE     = 2'd0,
    BBE_ERR_SPAN     = 2'd1,
    BBE_ERR_UNMAPPED = 2'd2
  } bbe_err_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_CHECK = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_XFER  = 3'd3,
    SQ_FLUSH = 3'd4
  } bbe_state_e;

endpackage

// File: rtl/bbe_span_check.sv
module bbe_span_check
  import bbe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 7,
  parameter int LEN_W     = 8,
  parameter int SPAN      = 128,
  parameter int unsigned CODE_BASE = 32'h8000
) (
  input  logic              trap_null_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [PTR_W-1:0]  ptr,
  output bbe_err_e          verdict
);

  localparam logic [ADDR_W:0]  BASE_X = (ADDR_W+1)'(CODE_BASE);
  localparam logic [PTR_W+1:0] SPAN_X = (PTR_W+2)'(SPAN);

  logic [PTR_W+1:0] pos_end;
  logic [ADDR_W:0]  addr_end;
  logic             null_hit, code_hit, span_hit;

  always_comb begin
    pos_end  = (PTR_W+2)'(ptr) + (PTR_W+2)'(len);
    addr_end = (ADDR_W+1)'(addr) + (ADDR_W+1)'(len);
    null_hit = trap_null_en && (addr < ADDR_W'(4));
    code_hit = ((ADDR_W+1)'(addr) >= BASE_X) || (addr_end > BASE_X);
    span_hit = pos_end > SPAN_X;
    if (null_hit || code_hit) verdict = BBE_ERR_UNMAPPED;
    else if (span_hit)        verdict = BBE_ERR_SPAN;
    else                      verdict = BBE_ERR_NONE;
  end

endmodule

// File: rtl/bbe_regfile.sv
module bbe_regfile #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREGS),
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data
);

  logic [DATA_W-1:0] regs [NREGS];

  genvar b;
  generate
    for (b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < NREGS; i++) regs[i][b*8 +: 8] <= 8'h00;
        end else if (wr_be[b]) begin
          regs[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  endgenerate

  assign rd0_data = regs[rd0_idx];
  assign rd1_data = regs[rd1_idx];

endmodule

// File: rtl/bbe_sequencer.sv
module bbe_sequencer
  import bbe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 7,
  parameter int LEN_W     = 8,
  parameter int SPAN      = 128,
  parameter int LAT       = 2,
  parameter int unsigned CODE_BASE = 32'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_null_en,
  input  logic              cmd_valid,
  input  logic              cmd_store,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [PTR_W-1:0]  cmd_ptr,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [PTR_W-1:0]  src_ptr_o,
  input  logic [7:0]        src_byte_i,
  output logic              ld_we_o,
  output logic [PTR_W-1:0]  ld_ptr_o
);

  localparam int CNT_W = $clog2(LAT + 2);

  bbe_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              ld_v1_q, ld_v2_q;
  logic [PTR_W-1:0]  ld_p1_q, ld_p2_q;
  bbe_err_e          verdict;

  bbe_span_check #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W),
    .SPAN(SPAN), .CODE_BASE(CODE_BASE)
  ) u_check (
    .trap_null_en(trap_null_en),
    .addr(addr_q),
    .len(left_q),
    .ptr(ptr_q),
    .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      cnt_q       <= '0;
      store_q     <= 1'b0;
      addr_q      <= '0;
      left_q      <= '0;
      ptr_q       <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_code_o  <= 2'd0;
      mem_en_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= 8'h00;
      ld_v1_q     <= 1'b0;
      ld_v2_q     <= 1'b0;
      ld_p1_q     <= '0;
      ld_p2_q     <= '0;
    end else begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      mem_en_o <= 1'b0;
      mem_we_o <= 1'b0;
      ld_v1_q  <= 1'b0;
      ld_v2_q  <= ld_v1_q;
      ld_p2_q  <= ld_p1_q;
      case (state_q)
        SQ_IDLE: begin
          if (cmd_valid) begin
            store_q <= cmd_store;
            addr_q  <= cmd_addr;
            left_q  <= cmd_len;
            ptr_q   <= cmd_ptr;
            state_q <= SQ_CHECK;
          end
        end
        SQ_CHECK: begin
          if (verdict != BBE_ERR_NONE) begin
            err_o      <= 1'b1;
            err_code_o <= verdict;
            state_q    <= SQ_IDLE;
          end else if (left_q == '0) begin
            done_o     <= 1'b1;
            err_code_o <= 2'd0;
            state_q    <= SQ_IDLE;
          end else begin
            err_code_o <= 2'd0;
            cnt_q      <= '0;
            state_q    <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (cnt_q == CNT_W'(LAT - 1)) begin
            cnt_q   <= '0;
            state_q <= SQ_XFER;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SQ_XFER: begin
          mem_en_o    <= 1'b1;
          mem_we_o    <= store_q;
          mem_addr_o  <= addr_q;
          mem_wdata_o <= src_byte_i;
          ld_v1_q     <= ~store_q;
          ld_p1_q     <= ptr_q;
          ptr_q       <= ptr_q + PTR_W'(1);
          addr_q      <= addr_q + ADDR_W'(1);
          left_q      <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            cnt_q   <= '0;
            state_q <= SQ_FLUSH;
          end
        end
        SQ_FLUSH: begin
          if (cnt_q == CNT_W'(1)) begin
            done_o  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != SQ_IDLE);
  assign src_ptr_o = ptr_q;
  assign ld_we_o   = ld_v2_q;
  assign ld_ptr_o  = ld_p2_q;

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && $past(mem_en_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  assert_refuse_silent_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!mem_en_o && !ld_v2_q));

  assert_take_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cmd_valid));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_en_o && !busy_o));

endmodule

// File: rtl/byte_burst_engine.sv
module byte_burst_engine #(
  parameter int ADDR_W = 16,
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int LAT    = 2,
  parameter int unsigned CODE_BASE = 32'h8000,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDX_W  = $clog2(NREGS),
  localparam int SPAN   = NREGS * LANES,
  localparam int PTR_W  = $clog2(SPAN),
  localparam int LEN_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_null_en,
  input  logic              cmd_valid,
  input  logic              cmd_store,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [IDX_W-1:0]  cmd_reg,
  input  logic [LANE_W-1:0] cmd_lane,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              rf_wr_en,
  input  logic [IDX_W-1:0]  rf_wr_idx,
  input  logic [DATA_W-1:0] rf_wr_data,
  input  logic [IDX_W-1:0]  rf_rd_idx,
  output logic [DATA_W-1:0] rf_rd_data
);

  logic [PTR_W-1:0]  src_ptr, ld_ptr;
  logic              ld_we;
  logic [DATA_W-1:0] src_word;
  logic [7:0]        src_byte;
  logic [IDX_W-1:0]  wr_idx;
  logic [LANES-1:0]  wr_be;
  logic [DATA_W-1:0] wr_data;

  bbe_sequencer #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .SPAN(SPAN),
    .LAT(LAT), .CODE_BASE(CODE_BASE)
  ) u_seq (
    .clk(clk), .rst(rst), .trap_null_en(trap_null_en),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_ptr({cmd_reg, cmd_lane}),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .src_ptr_o(src_ptr), .src_byte_i(src_byte),
    .ld_we_o(ld_we), .ld_ptr_o(ld_ptr)
  );

  assign src_byte = src_word[src_ptr[LANE_W-1:0]*8 +: 8];

  always_comb begin
    if (ld_we) begin
      wr_idx  = ld_ptr[PTR_W-1:LANE_W];
      wr_data = {LANES{mem_rdata_i}};
      for (int b = 0; b < LANES; b++)
        wr_be[b] = (ld_ptr[LANE_W-1:0] == LANE_W'(b));
    end else begin
      wr_idx  = rf_wr_idx;
      wr_data = rf_wr_data;
      wr_be   = {LANES{rf_wr_en}};
    end
  end

  bbe_regfile #(
    .NREGS(NREGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .LANES(LANES)
  ) u_rf (
    .clk(clk), .rst(rst),
    .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(wr_data),
    .rd0_idx(rf_rd_idx), .rd0_data(rf_rd_data),
    .rd1_idx(src_ptr[PTR_W-1:LANE_W]), .rd1_data(src_word)
  );

  assert_load_single_lane_R4: assert property (@(posedge clk) disable iff (rst)
    ld_we |-> $onehot(wr_be));

endmodule

// File: tb/byte_burst_engine_tb.sv
module byte_burst_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        trap_null_en;
  logic        cmd_valid, cmd_store;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_len;
  logic [4:0]  cmd_reg;
  logic [1:0]  cmd_lane;
  logic        busy_o, done_o, err_o;
  logic [1:0]  err_code_o;
  logic        mem_en_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx, rf_rd_idx;
  logic [31:0] rf_wr_data, rf_rd_data;

  always #4 clk = ~clk;

  byte_burst_engine dut_i (
    .clk(clk), .rst(rst), .trap_null_en(trap_null_en),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_reg(cmd_reg), .cmd_lane(cmd_lane),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int acc_cnt = 0;
  bit finished = 0;
  logic [7:0] bmem [256];

  typedef struct {
    bit         is_err;
    logic [1:0] code;
    int         cyc;
    string      tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;
      else          mem_rdata <= bmem[mem_addr_o[7:0]];
      acc_cnt <= acc_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results from the scoreboard as pulses appear
  always @(negedge clk) begin
    if (!rst && (done_o || err_o)) begin
      exp_t e;
      chk("R12 done/err exclusive", {30'd0, done_o, err_o} == 32'd3 ? 32'd1 : 32'd0, 32'd0);
      if (sb.size() == 0) begin
        chk("R2 unexpected result pulse", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk({e.tag, " kind"}, {31'd0, err_o}, {31'd0, e.is_err});
        chk({e.tag, " code"}, {30'd0, err_code_o}, {30'd0, e.code});
        chk({e.tag, " R10 cycle"}, cyc, e.cyc);
      end
    end
  end

  task automatic wr_reg(input int idx, input logic [31:0] val);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = 5'(idx); rf_wr_data = val;
    @(negedge clk);
    rf_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] val);
    rf_rd_idx = 5'(idx);
    #1 val = rf_rd_data;
  endtask

  // driver: issues one command, queues the expected outcome, waits for it
  task automatic run_cmd(input string tag, input bit st, input int addr, input int len,
                         input int r, input int lane, input bit is_err,
                         input logic [1:0] code, input int lat);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    e.is_err = is_err; e.code = code; e.tag = tag; e.cyc = cyc + 1 + lat;
    sb.push_back(e);
    cmd_valid = 1'b1; cmd_store = st; cmd_addr = 16'(addr);
    cmd_len = 8'(len); cmd_reg = 5'(r); cmd_lane = 2'(lane);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (sb.size() != 0 || busy_o) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int a0;
    for (int i = 0; i < 256; i++) bmem[i] = pat(i);
    rst = 1'b1; trap_null_en = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0;
    cmd_addr = '0; cmd_len = '0; cmd_reg = '0; cmd_lane = '0;
    rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0; rf_rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done/err", {30'd0, done_o, err_o}, 32'd0);
    chk("R1 mem_en", {31'd0, mem_en_o}, 32'd0);
    chk("R1 err_code", {30'd0, err_code_o}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      rd_reg(i, v);
      chk($sformatf("R1 reg %0d", i), v, 32'd0);
    end

    wr_reg(3, 32'h44332211);
    wr_reg(4, 32'h88776655);
    wr_reg(5, 32'hCCBBAA99);
    wr_reg(10, 32'hDEADBEEF);
    wr_reg(11, 32'h01234567);

    // R3 R5 store from mid-register lane, crossing into next register
    a0 = acc_cnt;
    run_cmd("R3 store r3.2 x5", 1'b1, 32'h20, 5, 3, 2, 1'b0, 2'd0, 10);
    chk("R5 access count", acc_cnt - a0, 5);
    chk("R3 mem20", {24'd0, bmem[8'h20]}, 32'h33);
    chk("R3 mem21", {24'd0, bmem[8'h21]}, 32'h44);
    chk("R3 mem22", {24'd0, bmem[8'h22]}, 32'h55);
    chk("R3 mem24", {24'd0, bmem[8'h24]}, 32'h77);
    chk("R5 mem1F untouched", {24'd0, bmem[8'h1F]}, {24'd0, pat(32'h1F)});
    chk("R5 mem25 untouched", {24'd0, bmem[8'h25]}, {24'd0, pat(32'h25)});

    // R4 load merging into lanes 1..3 of r10 and 0..2 of r11
    run_cmd("R4 load r10.1 x6", 1'b0, 32'h40, 6, 10, 1, 1'b0, 2'd0, 11);
    rd_reg(10, v);
    chk("R4 r10 merge", v, {pat(32'h42), pat(32'h41), pat(32'h40), 8'hEF});
    rd_reg(11, v);
    chk("R4 r11 merge", v, {8'h01, pat(32'h45), pat(32'h44), pat(32'h43)});

    // R6 boundary: full 128-byte store is legal
    a0 = acc_cnt;
    run_cmd("R6 full span store", 1'b1, 32'h80, 128, 0, 0, 1'b0, 2'd0, 133);
    chk("R6 full span count", acc_cnt - a0, 128);
    chk("R6 r3 byte0 at 0x8C", {24'd0, bmem[8'h8C]}, 32'h11);
    chk("R6 r4 byte3 at 0x93", {24'd0, bmem[8'h93]}, 32'h88);

    // R6 one past the end is refused, registers untouched
    a0 = acc_cnt;
    run_cmd("R6 span overflow", 1'b0, 32'h10, 2, 31, 3, 1'b1, 2'd1, 1);
    chk("R6 no access", acc_cnt - a0, 0);
    rd_reg(31, v);
    chk("R6 r31 untouched", v, 32'd0);
    run_cmd("R6 last lane load", 1'b0, 32'h10, 1, 31, 3, 1'b0, 2'd0, 6);
    rd_reg(31, v);
    chk("R6 r31 lane3", v, {pat(32'h10), 24'd0});

    // R7 null trap option
    trap_null_en = 1'b1;
    a0 = acc_cnt;
    run_cmd("R7 null trapped", 1'b0, 2, 1, 20, 0, 1'b1, 2'd2, 1);
    chk("R7 no access", acc_cnt - a0, 0);
    rd_reg(20, v);
    chk("R7 r20 untouched", v, 32'd0);
    run_cmd("R7 addr4 allowed", 1'b1, 4, 1, 3, 1, 1'b0, 2'd0, 6);
    chk("R7 mem4", {24'd0, bmem[4]}, 32'h22);
    // R9 address cause wins over span cause
    run_cmd("R9 priority", 1'b0, 0, 5, 31, 3, 1'b1, 2'd2, 1);
    trap_null_en = 1'b0;
    run_cmd("R7 trap off", 1'b0, 2, 1, 20, 0, 1'b0, 2'd0, 6);
    rd_reg(20, v);
    chk("R7 r20 loaded", v, {24'd0, pat(2)});

    // R8 instruction region
    a0 = acc_cnt;
    run_cmd("R8 inside code", 1'b1, 32'h8000, 1, 3, 0, 1'b1, 2'd2, 1);
    run_cmd("R8 crossing code", 1'b1, 32'h7FFE, 3, 3, 0, 1'b1, 2'd2, 1);
    chk("R8 no access", acc_cnt - a0, 0);
    run_cmd("R8 ends at base", 1'b1, 32'h7FFE, 2, 4, 0, 1'b0, 2'd0, 7);
    chk("R8 memFE", {24'd0, bmem[8'hFE]}, 32'h55);
    chk("R8 memFF", {24'd0, bmem[8'hFF]}, 32'h66);

    // R11 zero length
    a0 = acc_cnt;
    run_cmd("R11 zero length", 1'b1, 32'h50, 0, 3, 0, 1'b0, 2'd0, 1);
    chk("R11 no access", acc_cnt - a0, 0);

    // R2 command while busy is dropped
    begin
      exp_t e;
      @(negedge clk);
      e.is_err = 1'b0; e.code = 2'd0; e.tag = "R2 busy store"; e.cyc = cyc + 1 + 9;
      sb.push_back(e);
      cmd_valid = 1'b1; cmd_store = 1'b1; cmd_addr = 16'h30; cmd_len = 8'd4;
      cmd_reg = 5'd3; cmd_lane = 2'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1; cmd_store = 1'b0; cmd_addr = 16'h60; cmd_len = 8'd4;
      cmd_reg = 5'd3; cmd_lane = 2'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (sb.size() != 0 || busy_o) @(negedge clk);
      repeat (12) @(negedge clk);
      rd_reg(3, v);
      chk("R2 r3 unchanged", v, 32'h44332211);
      chk("R2 mem30", {24'd0, bmem[8'h30]}, 32'h11);
      chk("R2 mem33", {24'd0, bmem[8'h33]}, 32'h44);
      chk("R2 idle", {31'd0, busy_o}, 32'd0);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule